// File: doc/BRIEF.md
# Page write buffer and commit timer

This block sits behind a two-wire memory protocol engine and turns one write transaction into a single timed programming cycle. The engine first loads a start address. That address gives the page row and the in-page offset. The engine then streams data bytes into the block. Each accepted byte lands in a page-sized staging buffer at the current offset and sets that entry's valid flag. Only the low offset bits advance, so a long burst wraps inside the page and replaces earlier bytes.

When the engine reports the stop condition, the block copies every flagged byte into a behavioural byte array in one step and then raises a busy flag for a fixed number of clock cycles. A write-protect input blocks the copy. A stop with nothing buffered does nothing. A read port returns any array byte one cycle after its address is presented, so the engine can serve reads.

The byte stream uses a valid/ready handshake. A byte is taken on a clock edge where `wb_valid` and `wb_ready` are both high. `wb_ready` drops while the write cycle is busy, and in any cycle where an address load or a stop is presented, so the source must hold its byte until ready returns. An address load takes priority over a stop presented in the same cycle. Load and stop are single-cycle control strobes, not handshaked.

Top module: `page_write_commit`

## Requirements
- R1: After reset, `cycle_busy` is 0, `wb_ready` is 1, and every array byte reads 8'hFF.
- R2: An address load accepted while idle sets the page row from the upper address bits and the offset from the low log2(PAGE_BYTES) bits, and clears all buffer valid flags. `wb_ready` is 0 in the cycle the load is presented.
- R3: Each accepted byte is stored at the current offset, and the offset then advances by one. The page row never changes between loads.
- R4: After the last offset of a page, the next byte goes to offset 0 of the same page. A later byte at an offset replaces the byte buffered there earlier in the same transaction.
- R5: A commit changes only the bytes received in that transaction. All other bytes of the page and of the array keep their values.
- R6: A stop accepted while idle, with at least one byte buffered and `protect` low, writes the buffered bytes into the array at that clock edge. `cycle_busy` then reads 1 for exactly WR_CYCLES cycles, starting in the cycle after that edge.
- R7: A stop with no byte buffered, such as the address-only phase of a random read, writes nothing and leaves `cycle_busy` low.
- R8: If `protect` is 1 when a stop is accepted, the array is unchanged, `cycle_busy` stays low, and the buffered bytes are discarded.
- R9: While `cycle_busy` is 1, `wb_ready` is 0, and address loads and stops have no effect. A stop during the window does not extend it.
- R10: `rd_data` shows the array byte at `rd_addr` on the clock edge after the address is applied.
- R11: Every accepted stop clears the valid flags, so a later stop without new bytes commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_load | input | 1 | Start a write transaction with `txn_addr` |
| txn_addr | input | ADDR_W | Start address: page row in the upper bits, offset in the low bits |
| wb_valid | input | 1 | Data byte offered |
| wb_ready | output | 1 | Data byte can be taken this cycle |
| wb_data | input | 8 | Data byte |
| txn_stop | input | 1 | Stop condition seen; commit request |
| protect | input | 1 | High blocks every array write |
| cycle_busy | output | 1 | Timed write cycle in progress |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 8 | Registered read data |

## Verification
The bench builds the block with 16-byte pages, 8 pages and a 20-cycle write window. With these values, random bursts of up to 40 bytes wrap a page more than twice, and every page is hit often. The full array can be read back after every transaction. The short window lets the bench count every busy cycle exactly and inject loads, stops and bytes inside the window. The directed cases cover the reset contents, a wrap from offset 13, a partial rewrite, an address-only stop, a protected stop and a repeated stop.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  // What an accepted stop does with the staged bytes
  typedef enum logic [1:0] {
    STOP_NONE   = 2'd0,
    STOP_COMMIT = 2'd1,
    STOP_DROP   = 2'd2
  } stop_kind_e;
endpackage

// File: rtl/pwc_page_buffer.sv
module pwc_page_buffer
  import pwc_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 64,
  parameter int unsigned ROW_W      = 5,
  localparam int unsigned OFS_W     = $clog2(PAGE_BYTES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load_i,
  input  logic [ROW_W+OFS_W-1:0]       load_addr_i,
  input  logic                         take_i,
  input  byte_t                        byte_i,
  input  logic                         clear_i,
  output logic [ROW_W-1:0]             row_o,
  output byte_t [PAGE_BYTES-1:0]       data_o,
  output logic  [PAGE_BYTES-1:0]       vld_o,
  output logic                         any_o
);
  logic [OFS_W-1:0] ofs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_o  <= '0;
      ofs_q  <= '0;
      vld_o  <= '0;
      data_o <= '0;
    end else if (load_i) begin
      row_o <= load_addr_i[ROW_W+OFS_W-1:OFS_W];
      ofs_q <= load_addr_i[OFS_W-1:0];
      vld_o <= '0;
    end else begin
      if (clear_i) vld_o <= '0;
      if (take_i) begin
        data_o[ofs_q] <= byte_i;
        vld_o[ofs_q]  <= 1'b1;
        ofs_q         <= ofs_q + 1'b1;  // low bits only: wraps inside the page
      end
    end
  end

  assign any_o = |vld_o;

  // Row is held between loads
  p_row_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(row_o));

  // New transaction starts with no staged bytes
  p_flags_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (vld_o == '0));

  // A taken byte adds at most one flag
  p_one_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !load_i && !clear_i) |=> ($countones(vld_o) <= $past($countones(vld_o)) + 1));
endmodule

// File: rtl/pwc_commit_timer.sv
module pwc_commit_timer #(
  parameter int unsigned WR_CYCLES = 1000,
  localparam int unsigned CNT_W    = $clog2(WR_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (start_i && !busy_o) cnt_q <= CNT_W'(WR_CYCLES);
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  // Window length check through an independent run counter
  logic [CNT_W:0] run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)      run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  p_window_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (run_q == (CNT_W+1)'(WR_CYCLES)));

  p_no_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (run_q < (CNT_W+1)'(WR_CYCLES)));
endmodule

// File: rtl/pwc_page_array.sv
module pwc_page_array
  import pwc_pkg::*;
#(
  parameter int unsigned PAGES      = 32,
  parameter int unsigned PAGE_BYTES = 64,
  localparam int unsigned OFS_W     = $clog2(PAGE_BYTES),
  localparam int unsigned ROW_W     = $clog2(PAGES),
  localparam int unsigned ADDR_W    = ROW_W + OFS_W,
  localparam int unsigned DEPTH     = PAGES * PAGE_BYTES
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en_i,
  input  logic [ROW_W-1:0]       row_i,
  input  byte_t [PAGE_BYTES-1:0] data_i,
  input  logic  [PAGE_BYTES-1:0] vld_i,
  input  logic [ADDR_W-1:0]      rd_addr_i,
  output byte_t                  rd_data_o
);
  byte_t mem [DEPTH];
  logic [PAGE_BYTES-1:0] lane_we;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
    assign lane_we[g] = wr_en_i & vld_i[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      for (int j = 0; j < PAGE_BYTES; j++) begin
        if (lane_we[j]) mem[{row_i, OFS_W'(j)}] <= data_i[j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data_o <= 8'hFF;
    else        rd_data_o <= mem[rd_addr_i];
  end
endmodule

// File: rtl/page_write_commit.sv
module page_write_commit
  import pwc_pkg::*;
#(
  parameter int unsigned PAGES      = 32,
  parameter int unsigned PAGE_BYTES = 64,
  parameter int unsigned WR_CYCLES  = 1000,
  localparam int unsigned OFS_W     = $clog2(PAGE_BYTES),
  localparam int unsigned ROW_W     = $clog2(PAGES),
  localparam int unsigned ADDR_W    = ROW_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_load,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic              wb_valid,
  output logic              wb_ready,
  input  logic [7:0]        wb_data,
  input  logic              txn_stop,
  input  logic              protect,
  output logic              cycle_busy,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  logic                   load_acc, stop_acc, take;
  logic [ROW_W-1:0]       row;
  byte_t [PAGE_BYTES-1:0] stage;
  logic  [PAGE_BYTES-1:0] vld;
  logic                   any;
  stop_kind_e             kind;

  assign load_acc = txn_load & ~cycle_busy;
  assign stop_acc = txn_stop & ~cycle_busy & ~txn_load;
  assign wb_ready = ~cycle_busy & ~txn_load & ~txn_stop;
  assign take     = wb_valid & wb_ready;

  always_comb begin
    if (!stop_acc)            kind = STOP_NONE;
    else if (any && !protect) kind = STOP_COMMIT;
    else                      kind = STOP_DROP;
  end

  pwc_page_buffer #(.PAGE_BYTES(PAGE_BYTES), .ROW_W(ROW_W)) u_buf (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_acc),
    .load_addr_i (txn_addr),
    .take_i      (take),
    .byte_i      (wb_data),
    .clear_i     (kind != STOP_NONE),
    .row_o       (row),
    .data_o      (stage),
    .vld_o       (vld),
    .any_o       (any)
  );

  pwc_commit_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (kind == STOP_COMMIT),
    .busy_o  (cycle_busy)
  );

  pwc_page_array #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (kind == STOP_COMMIT),
    .row_i     (row),
    .data_i    (stage),
    .vld_i     (vld),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  p_ready_off_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_busy |-> !wb_ready);

  p_protect_no_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_stop && protect && !cycle_busy) |=> !cycle_busy);

  p_empty_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_stop && !txn_load && !cycle_busy && !any) |=> !cycle_busy);

  p_busy_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cycle_busy) |-> $past(txn_stop && !protect));

  p_stop_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_stop && !txn_load && !cycle_busy) |=> !any);
endmodule

// File: tb/sim_page_write_commit.sv
`timescale 1ns/1ps
module sim_page_write_commit;
  localparam int PB = 16;
  localparam int NP = 8;
  localparam int WR = 20;
  localparam int AW = 7;
  localparam int DEPTH = PB * NP;

  logic clk = 1'b0, rst_n = 1'b0;
  logic txn_load = 0, wb_valid = 0, txn_stop = 0, protect = 0;
  logic [AW-1:0] txn_addr = '0, rd_addr = '0;
  logic [7:0] wb_data = '0;
  logic wb_ready, cycle_busy;
  logic [7:0] rd_data;

  always #2.5 clk = ~clk;

  page_write_commit #(.PAGES(NP), .PAGE_BYTES(PB), .WR_CYCLES(WR)) u0 (
    .clk(clk), .rst_n(rst_n), .txn_load(txn_load), .txn_addr(txn_addr),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_data(wb_data),
    .txn_stop(txn_stop), .protect(protect), .cycle_busy(cycle_busy),
    .rd_addr(rd_addr), .rd_data(rd_data));

  int checks = 0, errors = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] bdat [PB];
  logic       bvld [PB];
  int brow = 0, bofs = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit model_any();
    for (int i = 0; i < PB; i++) if (bvld[i]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic do_load(input int addr);
    txn_load = 1; txn_addr = AW'(addr);
    #1 check("R2", "ready during load", wb_ready, 0);
    @(negedge clk); txn_load = 0;
    brow = addr / PB; bofs = addr % PB;
    for (int i = 0; i < PB; i++) bvld[i] = 0;
  endtask

  task automatic push_byte(input logic [7:0] d, input int gap);
    for (int g = 0; g < gap; g++) @(negedge clk);
    wb_valid = 1; wb_data = d;
    #1 check("R3", "ready for byte", wb_ready, 1);
    @(negedge clk); wb_valid = 0;
    bdat[bofs] = d; bvld[bofs] = 1; bofs = (bofs + 1) % PB;
  endtask

  task automatic do_stop(input bit wp, input string req);
    bit exp;
    int cnt;
    exp = model_any() && !wp;
    txn_stop = 1; protect = wp;
    @(negedge clk); txn_stop = 0; protect = 0;
    check(req, "busy after stop", cycle_busy, exp);
    if (exp) begin
      for (int i = 0; i < PB; i++) if (bvld[i]) model[brow*PB + i] = bdat[i];
      cnt = 0;
      while (cycle_busy && cnt < 1000) begin cnt++; @(negedge clk); end
      check("R6", "busy length", cnt, WR);
    end
    for (int i = 0; i < PB; i++) bvld[i] = 0;
  endtask

  task automatic read_chk(input int addr, input string req);
    rd_addr = AW'(addr);
    @(negedge clk);
    check(req, $sformatf("byte at %0d", addr), rd_data, model[addr]);
  endtask

  task automatic read_page(input int row, input string req);
    for (int i = 0; i < PB; i++) read_chk(row*PB + i, req);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++; checks++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cnt;
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    for (int i = 0; i < PB; i++) begin bvld[i] = 0; bdat[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", "busy after reset", cycle_busy, 0);
    check("R1", "ready after reset", wb_ready, 1);
    for (int a = 0; a < DEPTH; a++) read_chk(a, "R1");

    // R3 R6 full page
    do_load(2*PB);
    for (int i = 0; i < PB; i++) push_byte(8'h10 + 8'(i), i % 2);
    do_stop(0, "R6");
    read_page(2, "R10");

    // R4 wrap from offset 13, 20 bytes
    do_load(3*PB + 13);
    for (int i = 0; i < 20; i++) push_byte(8'h80 + 8'(i), 0);
    do_stop(0, "R6");
    read_page(3, "R4");

    // R5 partial rewrite
    do_load(2*PB + 5);
    for (int i = 0; i < 3; i++) push_byte(8'hA0 + 8'(i), 1);
    do_stop(0, "R6");
    read_page(2, "R5");
    read_page(3, "R5");

    // R7 address-only stop
    do_load(1*PB + 4);
    do_stop(0, "R7");
    read_page(1, "R7");

    // R8 protected stop, then stop again: nothing left (R11)
    do_load(2*PB);
    for (int i = 0; i < 4; i++) push_byte(8'h55, 0);
    do_stop(1, "R8");
    read_page(2, "R8");
    do_stop(0, "R11");
    read_page(2, "R11");

    // R9 activity during busy window
    do_load(4*PB);
    for (int i = 0; i < 5; i++) push_byte(8'hC0 + 8'(i), 0);
    txn_stop = 1;
    @(negedge clk); txn_stop = 0;
    for (int i = 0; i < PB; i++) if (bvld[i]) model[4*PB + i] = bdat[i];
    for (int i = 0; i < PB; i++) bvld[i] = 0;
    check("R6", "busy after stop", cycle_busy, 1);
    cnt = 0;
    wb_valid = 1; wb_data = 8'hEE;
    while (cycle_busy && cnt < 1000) begin
      #1 check("R9", "ready while busy", wb_ready, 0);
      txn_load = (cnt == 3); txn_addr = AW'(5*PB);
      txn_stop = (cnt == 7);
      cnt++;
      @(negedge clk);
    end
    wb_valid = 0; txn_load = 0; txn_stop = 0;
    check("R9", "window not extended", cnt, WR);
    do_stop(0, "R9");
    read_page(4, "R9");
    read_page(5, "R9");

    // Random transactions
    for (int t = 0; t < 40; t++) begin
      int addr, n;
      bit wp;
      addr = $urandom_range(0, DEPTH-1);
      n    = $urandom_range(0, 40);
      wp   = ($urandom_range(0, 5) == 0);
      do_load(addr);
      for (int i = 0; i < n; i++) push_byte(8'($urandom), $urandom_range(0, 2));
      do_stop(wp, wp ? "R8" : (n == 0 ? "R7" : "R6"));
      read_page(addr / PB, n > PB ? "R4" : "R5");
    end
    for (int a = 0; a < DEPTH; a++) read_chk(a, "R10");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule